// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading descriptors from translation tables held in memory. A walk begins at a context table selected by a root pointer and a context number. It then descends through at most three further table levels. Each fetched 32-bit word is sorted by its two-bit type field. The walk either moves on to the next table, stops at a page of 16 MB, 256 KB or 4 KB, or stops with a fault code that gives the level and the reason.

After a successful walk the block sets the accessed flag of the final descriptor, and on a store it also sets the modified flag. The descriptor is written back to memory only if either flag changed. When translation is switched off, the address goes straight through without any memory traffic. An optional boot redirect sends instruction fetches to a boot ROM window. Permission checks, fault status registers and translation caching are left to the stages around this block.

Memory is reached through a request channel that uses valid/ready. Once `mreq_valid_o` is high, address, write enable and write data stay fixed until `mreq_ready_i` is seen high at a clock edge, so the memory may stall the walker as long as it needs. A read is answered by a single-cycle `mrsp_valid_i` pulse in some later cycle. A write is complete once it is accepted and gets no response. The walker has no back-pressure on the response side, so the memory must not send a response the walker is not waiting for.

Top module: `tbl_walker`

## Requirements
- R1: A walk first reads the descriptor at (root pointer << 4) + (context number << 2), zero-extended to 36 bits. A pointer descriptor gives the next table base as (descriptor with bits [1:0] cleared) << 4. To that base the walker adds 4 × VA[31:24] after the context level, 4 × VA[23:18] after level 1, and 4 × VA[17:12] after level 2.
- R2: Descriptor bits [1:0] select the type: 0 invalid, 1 pointer, 2 page, 3 reserved. Levels are numbered 0 (context) to 3. A failed walk reports fault_o = (level << 8) | (cause << 2). Cause 1 is an invalid descriptor. Cause 4 is a reserved descriptor, a page descriptor at level 0, or a pointer at level 3. fault_o is 0 on success.
- R3: A page descriptor at level 1, 2 or 3 ends the walk. size_o is then 2 for 16 MB, 1 for 256 KB or 0 for 4 KB. pa_o = (descriptor[31:8] << 12) + VA[23:0], VA[17:0] or VA[11:0] respectively. On a fault, pa_o and size_o are 0.
- R4: After a page is found, bit 5 (accessed) is set and, for a write access, bit 6 (modified) is set. The updated word is written back to the descriptor's own address only if it differs from the word that was read. Otherwise no write takes place.
- R5: With xlat_en_i low, an accepted start completes with done_o in the next cycle. No memory request is made, pa_o equals the zero-extended VA, size_o is 0, fault_o is 0 and rights_o is 3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R6: With xlat_en_i low, boot_en_i high and fetch_i high, pa_o = boot_base_i | VA[18:0] and rights_o = 3'b101. A data access under boot mode passes through as in R5. rights_o is 3'b000 after any table walk.
- R7: busy_o goes high in the cycle after a table walk is accepted and stays high until the cycle in which done_o pulses. A start_i seen while busy_o is high has no effect: the current walk ends with its own result and no further walk follows. A new start may be given in the done_o cycle.
- R8: While mreq_valid_o is high and mreq_ready_i is low, mreq_addr_o, mreq_we_o and mreq_wdata_o hold their values in the next cycle. Every read result is taken from the single-cycle mrsp_valid_i pulse.
- R9: After reset, busy_o, done_o and mreq_valid_o are low, and pa_o and fault_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a translation (taken only while idle) |
| va_i | input | 32 | Virtual address to translate |
| write_i | input | 1 | Access is a store |
| fetch_i | input | 1 | Access is an instruction fetch |
| xlat_en_i | input | 1 | Translation enable |
| boot_en_i | input | 1 | Boot redirect enable for fetches while translation is off |
| root_ptr_i | input | 32 | Context table root pointer |
| ctx_i | input | CTX_W | Context number |
| boot_base_i | input | 36 | Boot ROM base address |
| busy_o | output | 1 | Table walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 36 | Physical address result |
| size_o | output | 2 | Page size code (0 4 KB, 1 256 KB, 2 16 MB) |
| rights_o | output | 3 | Access rights for pass-through results |
| fault_o | output | 10 | Walk fault code, 0 on success |
| mreq_valid_o | output | 1 | Memory request valid |
| mreq_ready_i | input | 1 | Memory request accepted |
| mreq_addr_o | output | 36 | Memory word address |
| mreq_we_o | output | 1 | Request is a write |
| mreq_wdata_o | output | 32 | Write data |
| mrsp_valid_i | input | 1 | Read response valid (one cycle) |
| mrsp_data_i | input | 32 | Read response data |

## Verification
Two events can fall in the same cycle: the done pulse that ends one walk, and the start of the next walk. The bench starts each new walk in the very cycle where it sees done_o, so every later result also shows that this start was accepted and its address captured. A second case is a start raised while a walk is still busy. Here the bench changes the address in the same cycle and then checks that the first walk's result is reported unchanged and that busy_o stays low afterwards. Random ready stalls and response delays move the descriptor write-back and the final read against these events, and every outcome is compared with a bench model of the table format.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int VA_W      = 32;
  localparam int ENT_W     = 32;
  localparam int TBL_SHIFT = 4;
  localparam int PA_W      = VA_W + TBL_SHIFT;
  localparam int LVL_W     = 2;
  localparam int CAUSE_W   = 6;
  localparam int FC_W      = LVL_W + CAUSE_W + 2;
  localparam int REF_BIT   = 5;
  localparam int MOD_BIT   = 6;
  localparam int PG_SHIFT  = 12;
  localparam int RT_W      = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_INVALID = 6'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_BADTYPE = 6'd4;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_PTR     = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } etype_e;

  typedef enum logic [1:0] {
    DK_NEXT  = 2'd0,
    DK_LEAF  = 2'd1,
    DK_FAULT = 2'd2
  } dkind_e;

  typedef enum logic [1:0] {
    SZ_4K   = 2'd0,
    SZ_256K = 2'd1,
    SZ_16M  = 2'd2
  } pgsz_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WB_REQ  = 2'd3
  } wstate_e;
endpackage

// File: rtl/tw_decode.sv
`timescale 1ns/1ps
module tw_decode
  import tw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             write_i,
  output dkind_e           kind_o,
  output logic [PA_W-1:0]  next_addr_o,
  output logic [PA_W-1:0]  leaf_pa_o,
  output pgsz_e            size_o,
  output logic [FC_W-1:0]  fault_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             upd_need_o
);
  etype_e              ety;
  logic [PA_W-1:0]     tbl_base;
  logic [PA_W-1:0]     tbl_idx;
  logic [PA_W-1:0]     frame;
  logic [PA_W-1:0]     ofs;
  logic [CAUSE_W-1:0]  cause;

  assign ety      = etype_e'(entry_i[1:0]);
  assign tbl_base = PA_W'({entry_i[ENT_W-1:2], 2'b00}) << TBL_SHIFT;
  assign frame    = PA_W'(entry_i[ENT_W-1:8]) << PG_SHIFT;

  always_comb begin
    case (lvl_i)
      2'd0:    tbl_idx = PA_W'({va_i[31:24], 2'b00});
      2'd1:    tbl_idx = PA_W'({va_i[23:18], 2'b00});
      default: tbl_idx = PA_W'({va_i[17:12], 2'b00});
    endcase
  end

  always_comb begin
    case (lvl_i)
      2'd1:    ofs = PA_W'(va_i[23:0]);
      2'd2:    ofs = PA_W'(va_i[17:0]);
      default: ofs = PA_W'(va_i[11:0]);
    endcase
  end

  always_comb begin
    kind_o = DK_FAULT;
    cause  = CAUSE_BADTYPE;
    size_o = SZ_4K;
    case (ety)
      ET_INVALID: cause = CAUSE_INVALID;
      ET_PTR:     if (lvl_i != 2'd3) kind_o = DK_NEXT;
      ET_PAGE: begin
        if (lvl_i != 2'd0) begin
          kind_o = DK_LEAF;
          if (lvl_i == 2'd1)      size_o = SZ_16M;
          else if (lvl_i == 2'd2) size_o = SZ_256K;
          else                    size_o = SZ_4K;
        end
      end
      default: cause = CAUSE_BADTYPE;
    endcase
  end

  assign next_addr_o = tbl_base + tbl_idx;
  assign leaf_pa_o   = frame + ofs;
  assign fault_o     = {lvl_i, cause, 2'b00};

  always_comb begin
    upd_o          = entry_i;
    upd_o[REF_BIT] = 1'b1;
    if (write_i) upd_o[MOD_BIT] = 1'b1;
  end

  assign upd_need_o = (upd_o != entry_i);
endmodule

// File: rtl/tw_bypass.sv
`timescale 1ns/1ps
module tw_bypass
  import tw_pkg::*;
#(
  parameter int BOOT_OFS_W = 19
) (
  input  logic [VA_W-1:0] va_i,
  input  logic            fetch_i,
  input  logic            boot_en_i,
  input  logic [PA_W-1:0] boot_base_i,
  output logic [PA_W-1:0] pa_o,
  output logic [RT_W-1:0] rights_o
);
  localparam logic [RT_W-1:0] RT_ALL  = 3'b111;
  localparam logic [RT_W-1:0] RT_BOOT = 3'b101;

  logic boot_hit;
  assign boot_hit = fetch_i & boot_en_i;

  always_comb begin
    if (boot_hit) begin
      pa_o     = boot_base_i | PA_W'(va_i[BOOT_OFS_W-1:0]);
      rights_o = RT_BOOT;
    end else begin
      pa_o     = PA_W'(va_i);
      rights_o = RT_ALL;
    end
  end
endmodule

// File: rtl/tbl_walker.sv
`timescale 1ns/1ps
module tbl_walker
  import tw_pkg::*;
#(
  parameter int CTX_W      = 8,
  parameter int ROOT_W     = 32,
  parameter int BOOT_OFS_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic              xlat_en_i,
  input  logic              boot_en_i,
  input  logic [ROOT_W-1:0] root_ptr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [PA_W-1:0]   boot_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        size_o,
  output logic [RT_W-1:0]   rights_o,
  output logic [FC_W-1:0]   fault_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic [PA_W-1:0]   mreq_addr_o,
  output logic              mreq_we_o,
  output logic [ENT_W-1:0]  mreq_wdata_o,
  input  logic              mrsp_valid_i,
  input  logic [ENT_W-1:0]  mrsp_data_i
);
  localparam int CTX_SHIFT = 2;

  wstate_e            state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [PA_W-1:0]    addr_q;
  logic [ENT_W-1:0]   wdata_q;
  logic [PA_W-1:0]    pa_q;
  pgsz_e              size_q;
  logic [RT_W-1:0]    rights_q;
  logic [FC_W-1:0]    fault_q;
  logic               done_q;

  logic [PA_W-1:0]    ctx_addr;
  logic [PA_W-1:0]    byp_pa;
  logic [RT_W-1:0]    byp_rights;

  dkind_e             dec_kind;
  logic [PA_W-1:0]    dec_next;
  logic [PA_W-1:0]    dec_pa;
  pgsz_e              dec_size;
  logic [FC_W-1:0]    dec_fault;
  logic [ENT_W-1:0]   dec_upd;
  logic               dec_upd_need;

  assign ctx_addr = (PA_W'(root_ptr_i) << TBL_SHIFT) + (PA_W'(ctx_i) << CTX_SHIFT);

  tw_bypass #(.BOOT_OFS_W(BOOT_OFS_W)) u_bypass (
    .va_i        (va_i),
    .fetch_i     (fetch_i),
    .boot_en_i   (boot_en_i),
    .boot_base_i (boot_base_i),
    .pa_o        (byp_pa),
    .rights_o    (byp_rights)
  );

  tw_decode u_decode (
    .entry_i     (mrsp_data_i),
    .lvl_i       (lvl_q),
    .va_i        (va_q),
    .write_i     (wr_q),
    .kind_o      (dec_kind),
    .next_addr_o (dec_next),
    .leaf_pa_o   (dec_pa),
    .size_o      (dec_size),
    .fault_o     (dec_fault),
    .upd_o       (dec_upd),
    .upd_need_o  (dec_upd_need)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      lvl_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      pa_q     <= '0;
      size_q   <= SZ_4K;
      rights_q <= '0;
      fault_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q <= va_i;
            wr_q <= write_i;
            if (!xlat_en_i) begin
              pa_q     <= byp_pa;
              rights_q <= byp_rights;
              size_q   <= SZ_4K;
              fault_q  <= '0;
              done_q   <= 1'b1;
            end else begin
              lvl_q   <= '0;
              addr_q  <= ctx_addr;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (mreq_ready_i) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mrsp_valid_i) begin
            case (dec_kind)
              DK_NEXT: begin
                addr_q  <= dec_next;
                lvl_q   <= lvl_q + 2'd1;
                state_q <= ST_RD_REQ;
              end
              DK_LEAF: begin
                pa_q     <= dec_pa;
                size_q   <= dec_size;
                rights_q <= '0;
                fault_q  <= '0;
                if (dec_upd_need) begin
                  wdata_q <= dec_upd;
                  state_q <= ST_WB_REQ;
                end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                end
              end
              default: begin
                pa_q     <= '0;
                size_q   <= SZ_4K;
                rights_q <= '0;
                fault_q  <= dec_fault;
                state_q  <= ST_IDLE;
                done_q   <= 1'b1;
              end
            endcase
          end
        end
        ST_WB_REQ: begin
          if (mreq_ready_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign pa_o         = pa_q;
  assign size_o       = size_q;
  assign rights_o     = rights_q;
  assign fault_o      = fault_q;
  assign mreq_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WB_REQ);
  assign mreq_we_o    = (state_q == ST_WB_REQ);
  assign mreq_addr_o  = addr_q;
  assign mreq_wdata_o = wdata_q;
endmodule

// File: rtl/tw_walker_chk.sv
`timescale 1ns/1ps
module tw_walker_chk
  import tw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       size_o,
  input logic [FC_W-1:0]  fault_o,
  input logic             mreq_valid_o,
  input logic             mreq_ready_i,
  input logic [PA_W-1:0]  mreq_addr_o,
  input logic             mreq_we_o,
  input logic [ENT_W-1:0] mreq_wdata_o
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o)
      && $stable(mreq_we_o) && $stable(mreq_wdata_o));

  // R4
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o && mreq_we_o |-> mreq_wdata_o[REF_BIT]);

  // R2
  fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (fault_o != '0) |-> (fault_o[1:0] == 2'b00)
      && ((fault_o[7:2] == 6'd1) || (fault_o[7:2] == 6'd4)));

  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> busy_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R3
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (size_o != 2'd3));
endmodule

bind tbl_walker tw_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .size_o       (size_o),
  .fault_o      (fault_o),
  .mreq_valid_o (mreq_valid_o),
  .mreq_ready_i (mreq_ready_i),
  .mreq_addr_o  (mreq_addr_o),
  .mreq_we_o    (mreq_we_o),
  .mreq_wdata_o (mreq_wdata_o)
);

// File: tb/tbl_walker_tb.sv
`timescale 1ns/1ps
module tbl_walker_tb;
  import tw_pkg::*;
  localparam int CTX_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [31:0]       va_i = '0;
  logic              write_i = 1'b0;
  logic              fetch_i = 1'b0;
  logic              xlat_en_i = 1'b0;
  logic              boot_en_i = 1'b0;
  logic [31:0]       root_ptr_i = '0;
  logic [CTX_W-1:0]  ctx_i = '0;
  logic [35:0]       boot_base_i = '0;
  logic              busy_o, done_o;
  logic [35:0]       pa_o;
  logic [1:0]        size_o;
  logic [2:0]        rights_o;
  logic [9:0]        fault_o;
  logic              mreq_valid_o, mreq_we_o;
  logic              mreq_ready_i = 1'b0;
  logic [35:0]       mreq_addr_o;
  logic [31:0]       mreq_wdata_o;
  logic              mrsp_valid_i = 1'b0;
  logic [31:0]       mrsp_data_i = '0;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  tbl_walker #(.CTX_W(CTX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i),
    .write_i(write_i), .fetch_i(fetch_i), .xlat_en_i(xlat_en_i),
    .boot_en_i(boot_en_i), .root_ptr_i(root_ptr_i), .ctx_i(ctx_i),
    .boot_base_i(boot_base_i), .busy_o(busy_o), .done_o(done_o),
    .pa_o(pa_o), .size_o(size_o), .rights_o(rights_o), .fault_o(fault_o),
    .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i),
    .mreq_addr_o(mreq_addr_o), .mreq_we_o(mreq_we_o),
    .mreq_wdata_o(mreq_wdata_o), .mrsp_valid_i(mrsp_valid_i),
    .mrsp_data_i(mrsp_data_i)
  );

  // memory model
  logic [31:0] mem [logic [35:0]];
  int unsigned rd_cnt = 0;
  int unsigned wr_cnt = 0;
  int          pend = 0;
  logic [31:0] pend_data = '0;

  function automatic logic [31:0] mrd(logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      mrsp_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mrsp_valid_i = 1'b1;
          mrsp_data_i  = pend_data;
        end
      end
      mreq_ready_i = (($urandom % 4) != 0);
      if (mreq_valid_o && mreq_ready_i) begin
        if (mreq_we_o) begin
          mem[mreq_addr_o] = mreq_wdata_o;
          wr_cnt++;
        end else begin
          pend_data = mrd(mreq_addr_o);
          pend      = 1 + int'($urandom % 3);
          rd_cnt++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // table builder: types packed {t3,t2,t1,t0}; rm = {modified, accessed}
  task automatic build(input logic [7:0] types, input logic [1:0] rm);
    logic [35:0] a;
    logic [31:0] e;
    logic [31:0] r;
    logic [1:0]  tt;
    a = (36'(root_ptr_i) << 4) + (36'(ctx_i) << 2);
    for (int lv = 0; lv < 4; lv++) begin
      tt = types[lv*2 +: 2];
      r  = $urandom;
      case (tt)
        2'd1:    e = {2'(lv + 1), r[27:0], 2'b01};
        2'd2:    e = {r[31:7], rm[1], rm[0], r[4:2], 2'b10};
        2'd0:    e = {r[31:2], 2'b00};
        default: e = {r[31:2], 2'b11};
      endcase
      mem[a] = e;
      if (tt != 2'd1 || lv == 3) break;
      case (lv)
        0:       a = {e[31:2], 6'b0} + 36'({va_i[31:24], 2'b00});
        1:       a = {e[31:2], 6'b0} + 36'({va_i[23:18], 2'b00});
        default: a = {e[31:2], 6'b0} + 36'({va_i[17:12], 2'b00});
      endcase
    end
  endtask

  // expected result from the requirements
  task automatic model(output logic [35:0] epa, output logic [1:0] esz,
                       output logic [2:0] ert, output logic [9:0] efc,
                       output bit ewb, output logic [35:0] ewa,
                       output logic [31:0] ewd);
    logic [35:0] a;
    logic [31:0] e;
    bit          stop;
    epa = '0; esz = 2'd0; ert = 3'b000; efc = '0; ewb = 0; ewa = '0; ewd = '0;
    if (!xlat_en_i) begin
      if (boot_en_i && fetch_i) begin
        epa = boot_base_i | 36'(va_i[18:0]);
        ert = 3'b101;
      end else begin
        epa = 36'(va_i);
        ert = 3'b111;
      end
      return;
    end
    a = (36'(root_ptr_i) << 4) + (36'(ctx_i) << 2);
    stop = 0;
    for (int lv = 0; lv < 4 && !stop; lv++) begin
      e = mrd(a);
      stop = 1;
      if (e[1:0] == 2'd0) efc = {2'(lv), 6'd1, 2'b00};
      else if (e[1:0] == 2'd3) efc = {2'(lv), 6'd4, 2'b00};
      else if (e[1:0] == 2'd1) begin
        if (lv == 3) efc = {2'(lv), 6'd4, 2'b00};
        else begin
          stop = 0;
          case (lv)
            0:       a = {e[31:2], 6'b0} + 36'({va_i[31:24], 2'b00});
            1:       a = {e[31:2], 6'b0} + 36'({va_i[23:18], 2'b00});
            default: a = {e[31:2], 6'b0} + 36'({va_i[17:12], 2'b00});
          endcase
        end
      end else begin
        if (lv == 0) efc = {2'(lv), 6'd4, 2'b00};
        else begin
          case (lv)
            1:       begin epa = ({4'b0, e[31:8]} << 12) + 36'(va_i[23:0]); esz = 2'd2; end
            2:       begin epa = ({4'b0, e[31:8]} << 12) + 36'(va_i[17:0]); esz = 2'd1; end
            default: begin epa = ({4'b0, e[31:8]} << 12) + 36'(va_i[11:0]); esz = 2'd0; end
          endcase
          ewd = e | 32'h20 | (write_i ? 32'h40 : 32'h0);
          ewa = a;
          ewb = (ewd != e);
        end
      end
    end
  endtask

  task automatic walk(input string tag, input bit inject);
    logic [35:0] epa, ewa;
    logic [1:0]  esz;
    logic [2:0]  ert;
    logic [9:0]  efc;
    logic [31:0] ewd, keep_va;
    bit          ewb, injected;
    int unsigned w0, r0;
    int          n;
    model(epa, esz, ert, efc, ewb, ewa, ewd);
    w0 = wr_cnt; r0 = rd_cnt; keep_va = va_i;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (xlat_en_i) chk("R7", {tag, " busy after start"}, 64'(busy_o), 64'd1);
    n = 0; injected = 0;
    while (!done_o && n < 3000) begin
      if (inject && !injected && busy_o) begin
        start_i = 1'b1; va_i = ~keep_va; injected = 1;
      end else start_i = 1'b0;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    va_i = keep_va;
    chk("R7", {tag, " done seen"}, 64'(done_o), 64'd1);
    chk("R7", {tag, " idle at done"}, 64'(busy_o), 64'd0);
    chk("R3", {tag, " pa"}, 64'(pa_o), 64'(epa));
    chk("R3", {tag, " size"}, 64'(size_o), 64'(esz));
    chk("R2", {tag, " fault"}, 64'(fault_o), 64'(efc));
    chk("R6", {tag, " rights"}, 64'(rights_o), 64'(ert));
    chk("R4", {tag, " write count"}, 64'(wr_cnt - w0), ewb ? 64'd1 : 64'd0);
    if (ewb) chk("R4", {tag, " written word"}, 64'(mrd(ewa)), 64'(ewd));
    if (!xlat_en_i) chk("R5", {tag, " no reads"}, 64'(rd_cnt - r0), 64'd0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk("R7", {tag, " no second walk"}, 64'({busy_o, done_o}), 64'd0);
    end
  endtask

  task automatic setup(input logic [31:0] va, input bit we, input bit fe,
                       input bit xl, input bit bt);
    va_i = va; write_i = we; fetch_i = fe; xlat_en_i = xl; boot_en_i = bt;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ty;
    int         r;
    void'($urandom(32'h5EED_0071));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "busy", 64'(busy_o), 64'd0);
    chk("R9", "done", 64'(done_o), 64'd0);
    chk("R9", "mreq_valid", 64'(mreq_valid_o), 64'd0);
    chk("R9", "pa", 64'(pa_o), 64'd0);
    chk("R9", "fault", 64'(fault_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    root_ptr_i  = 32'h0000_1000;
    ctx_i       = 8'd3;
    boot_base_i = 36'hF_F000_0000;

    // R5 pass-through, R6 boot redirect
    setup(32'hDEAD_BEEF, 0, 1, 0, 0); walk("R5 bypass fetch", 0);
    setup(32'h1234_5678, 1, 0, 0, 0); walk("R5 bypass store", 0);
    setup(32'hCAFE_F00D, 0, 1, 0, 1); walk("R6 boot fetch", 0);
    setup(32'hCAFE_F00D, 0, 0, 0, 1); walk("R6 boot data", 0);

    // R1 R3 R4 leaves at each level
    setup(32'h89AB_CDEF, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd0, 2'd2, 2'd1}, 2'b00); walk("R3 16MB read", 0);
    setup(32'h4567_89AB, 1, 0, 1, 0); mem.delete(); build({2'd0, 2'd2, 2'd1, 2'd1}, 2'b01); walk("R4 256KB store", 0);
    setup(32'hFEDC_BA98, 1, 0, 1, 0); mem.delete(); build({2'd2, 2'd1, 2'd1, 2'd1}, 2'b11); walk("R4 4KB no change", 0);
    setup(32'h0F0F_3C3C, 0, 0, 1, 0); mem.delete(); build({2'd2, 2'd1, 2'd1, 2'd1}, 2'b01); walk("R4 4KB read accessed", 0);

    // R2 faults
    setup(32'h1111_2222, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd0, 2'd0, 2'd0}, 2'b00); walk("R2 ctx invalid", 0);
    setup(32'h1111_2222, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd0, 2'd0, 2'd2}, 2'b00); walk("R2 ctx page", 0);
    setup(32'h3333_4444, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd0, 2'd0, 2'd3}, 2'b00); walk("R2 ctx reserved", 0);
    setup(32'h5555_6666, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd0, 2'd0, 2'd1}, 2'b00); walk("R2 L1 invalid", 0);
    setup(32'h7777_8888, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd3, 2'd1, 2'd1}, 2'b00); walk("R2 L2 reserved", 0);
    setup(32'h9999_AAAA, 0, 0, 1, 0); mem.delete(); build({2'd0, 2'd1, 2'd1, 2'd1}, 2'b00); walk("R2 L3 invalid", 0);
    setup(32'hBBBB_CCCC, 0, 0, 1, 0); mem.delete(); build({2'd1, 2'd1, 2'd1, 2'd1}, 2'b00); walk("R2 L3 pointer", 0);

    // R7 start while busy is ignored
    setup(32'h2468_ACE0, 1, 0, 1, 0); mem.delete(); build({2'd2, 2'd1, 2'd1, 2'd1}, 2'b00); walk("R7 ignored start", 1);

    // random walks, each started in the done cycle of the previous one (R8 stalls)
    for (int it = 0; it < 300; it++) begin
      root_ptr_i  = {2'b00, 30'($urandom)};
      ctx_i       = CTX_W'($urandom);
      boot_base_i = 36'({$urandom, $urandom}) & 36'hF_FFF8_0000;
      fetch_i     = $urandom % 2;
      setup($urandom, fetch_i ? 1'b0 : 1'($urandom % 2), fetch_i,
            (($urandom % 10) != 0), 1'($urandom % 2));
      for (int lv = 0; lv < 4; lv++) begin
        r = int'($urandom % 100);
        ty[lv*2 +: 2] = (r < 60) ? 2'd1 : (r < 85) ? 2'd2 : (r < 93) ? 2'd0 : 2'd3;
      end
      mem.delete();
      build(ty, 2'($urandom));
      walk("R1 random", 0);
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule